// File: doc/BRIEF.md
# Equivalent-Time Sampling Controller

This block builds a picture of a repeating waveform at a rate far above the ADC's own conversion rate by taking a single sample per trigger event. Point k of a record is taken k fast-clock periods after its own trigger. Laid side by side in the order they were taken, the points show the waveform with a time resolution of one fast-clock period. A 200 MHz fast clock, four times a 50 MHz system clock, gives a 5 ns step and an equivalent rate of 200 MS/s. The clock multiplier is outside the block, and `clk` is that fast clock.

A mode bit, latched when the block is armed, selects one of two paths. The equivalent-time path waits for triggers and adds a growing delay. The real-time path streams one ADC sample into the FIFO on every clock. Both paths feed one FIFO write port through a selector. After a record of `NPTS` points the block raises `done`. In single mode it then waits for a new arm. In continuous mode it re-arms by itself as soon as the downstream FIFO reports that it is empty.

The controller has six states:
- `ST_IDLE`: waiting for the first arm.
- `ST_WAIT`: armed in equivalent-time mode, looking for a trigger edge.
- `ST_HOLD`: counting out the added delay.
- `ST_GRAB`: strobing the ADC and writing one point.
- `ST_STREAM`: real-time streaming.
- `ST_DONE`: the record is complete.

It has these transitions:
- IDLE→WAIT or IDLE→STREAM on `arm`, chosen by `mode_rt`.
- WAIT→GRAB on a trigger edge when the point index is 0.
- WAIT→HOLD on a trigger edge when the point index is not 0.
- HOLD→GRAB when the delay expires.
- GRAB→WAIT, or GRAB→DONE after the last point.
- STREAM→DONE after the last point.
- DONE→WAIT or DONE→STREAM on `arm`, or on `fifo_empty` when continuous mode is latched.

Top module: `ets_sampler`

## Requirements
- R1: In ST_IDLE the block ignores trigger edges and makes no ADC strobe. An `arm` pulse, in ST_IDLE or ST_DONE, starts a capture at point index 0 and latches `mode_rt` (1 = real-time, 0 = equivalent-time) and `cont` (1 = continuous, 0 = single).
- R2: In equivalent-time mode, the first trigger after arming is sampled with no added delay. Let E be the first clock edge that samples `trig` high. `adc_strobe` is then high in the cycle that begins one edge after E.
- R3: For point k (0-based), the strobe cycle begins k+1 edges after the edge that first samples that trigger high. Each trigger therefore adds one clock of delay.
- R4: A trigger that rises while a delayed sample is still pending, in ST_HOLD or ST_GRAB, is ignored. It causes no extra strobe and does not advance the point index.
- R5: Each equivalent-time point produces exactly one cycle with `fifo_wr` and `adc_strobe` both high. In that cycle `fifo_wdata` equals `adc_data`. Points are written in trigger order.
- R6: In real-time mode, `fifo_wr` and `adc_strobe` are high for exactly NPTS consecutive cycles. The first of these cycles begins at the edge that samples `arm` high, and no trigger is needed.
- R7: After NPTS points, `done` rises in the cycle after the last write. While `done` is high, no write and no strobe occur, and triggers are ignored.
- R8: In single mode, `done` stays high until the next `arm`.
- R9: In continuous mode, while `done` is high and `fifo_empty` is high, the block re-arms at the next edge in the latched mode: `done` falls and the capture restarts at point 0. While `fifo_empty` is low, `done` stays high.
- R10: After reset, `done`, `fifo_wr` and `adc_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Start a capture (one-cycle pulse) |
| mode_rt | input | 1 | 1 = real-time path, 0 = equivalent-time path; latched at arm |
| cont | input | 1 | 1 = continuous re-arm, 0 = single capture; latched at arm |
| trig | input | 1 | Trigger input, synchronous to clk; rising edge is an event |
| adc_data | input | DW | ADC conversion result |
| adc_strobe | output | 1 | ADC sample strobe |
| fifo_wr | output | 1 | FIFO write enable |
| fifo_wdata | output | DW | FIFO write data |
| fifo_empty | input | 1 | Downstream FIFO is empty (drained) |
| done | output | 1 | Capture complete |

## Verification
A wrong point index or delay count shows on the very next trigger as a strobe that comes one or more cycles early or late. The bench measures that latency for every point of a record. A state that fails to leave ST_HOLD or ST_GRAB on time shows as a missing strobe, or as a second strobe within a few cycles of the first. A stuck or early ST_DONE shows as a `done` edge that misses its expected cycle by the size of the error. In real-time mode, a miscount shows as a burst length different from NPTS, visible as soon as the burst ends.

// File: rtl/ets_pkg.sv
package ets_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_HOLD,
        ST_GRAB,
        ST_STREAM,
        ST_DONE
    } ets_state_t;
endpackage

// File: rtl/ets_edge.sv
module ets_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    logic cur_q;
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            cur_q  <= sig_in;
            prev_q <= cur_q;
        end
    end

    assign rise = cur_q & ~prev_q;
endmodule

// File: rtl/ets_delay.sv
module ets_delay #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          expire
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == CW'(1));

    // R3: a one-step delay expires right after loading
    p_one_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load && load_val == CW'(1) |=> expire);
endmodule

// File: rtl/ets_sampler.sv
module ets_sampler #(
    parameter int unsigned DW   = 8,
    parameter int unsigned NPTS = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          mode_rt,
    input  logic          cont,
    input  logic          trig,
    input  logic [DW-1:0] adc_data,
    output logic          adc_strobe,
    output logic          fifo_wr,
    output logic [DW-1:0] fifo_wdata,
    input  logic          fifo_empty,
    output logic          done
);
    import ets_pkg::*;

    localparam int unsigned IW = (NPTS > 2) ? $clog2(NPTS) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NPTS - 1);

    ets_state_t    state_q, state_d;
    logic [IW-1:0] idx_q;
    logic          mode_q, cont_q;
    logic          trig_rise, dly_expire, last_pt, start;
    logic          et_wr, rt_wr;

    ets_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (trig),
        .rise   (trig_rise)
    );

    ets_delay #(.CW(IW)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == ST_WAIT && trig_rise),
        .load_val (idx_q),
        .run      (state_q == ST_HOLD),
        .expire   (dly_expire)
    );

    assign last_pt = (idx_q == LAST_IDX);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm) state_d = mode_rt ? ST_STREAM : ST_WAIT;
            end
            ST_WAIT: begin
                if (trig_rise) state_d = (idx_q == '0) ? ST_GRAB : ST_HOLD;
            end
            ST_HOLD: begin
                if (dly_expire) state_d = ST_GRAB;
            end
            ST_GRAB: begin
                state_d = last_pt ? ST_DONE : ST_WAIT;
            end
            ST_STREAM: begin
                if (last_pt) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (arm) state_d = mode_rt ? ST_STREAM : ST_WAIT;
                else if (cont_q && fifo_empty) state_d = mode_q ? ST_STREAM : ST_WAIT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign start = (state_q == ST_IDLE || state_q == ST_DONE) &&
                   (state_d == ST_WAIT || state_d == ST_STREAM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            mode_q  <= 1'b0;
            cont_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                idx_q <= '0;
            end else if (state_q == ST_GRAB || state_q == ST_STREAM) begin
                idx_q <= idx_q + 1'b1;
            end
            if (arm && (state_q == ST_IDLE || state_q == ST_DONE)) begin
                mode_q <= mode_rt;
                cont_q <= cont;
            end
        end
    end

    always_comb begin
        et_wr      = (state_q == ST_GRAB);
        rt_wr      = (state_q == ST_STREAM);
        fifo_wr    = mode_q ? rt_wr : et_wr;
        adc_strobe = fifo_wr;
        fifo_wdata = adc_data;
        done       = (state_q == ST_DONE);
    end

    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !fifo_wr && !adc_strobe);

    p_first_point_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_WAIT && trig_rise && idx_q == '0 |=> adc_strobe);

    p_hold_ignores_trig_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HOLD && !dly_expire |=> state_q == ST_HOLD);

    p_one_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr && !mode_q |=> !fifo_wr);

    p_stream_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_STREAM && !last_pt |=> fifo_wr);

    p_single_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && !cont_q && !arm |=> done);

    p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done && cont_q && fifo_empty |=> !done);
endmodule

// File: tb/ets_sampler_bench.sv
module ets_sampler_bench;
    localparam int unsigned DW   = 8;
    localparam int unsigned NPTS = 16;

    // Stimulus table: idle gap before each trigger, and whether a stray
    // trigger is injected while that point's delay is still pending.
    localparam int unsigned GAP [NPTS] = '{3, 4, 2, 5, 3, 6, 2, 4, 3, 2, 7, 3, 4, 2, 5, 3};
    localparam bit          STRAY[NPTS] = '{0, 0, 0, 1, 0, 1, 0, 0, 1, 0, 0, 1, 0, 1, 0, 1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0, mode_rt = 1'b0, cont = 1'b0, trig = 1'b0;
    logic          fifo_empty = 1'b0;
    logic [DW-1:0] adc_data = '0;
    logic          adc_strobe, fifo_wr, done;
    logic [DW-1:0] fifo_wdata;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    ets_sampler #(.DW(DW), .NPTS(NPTS)) u_ets_sampler (
        .clk(clk), .rst_n(rst_n), .arm(arm), .mode_rt(mode_rt), .cont(cont),
        .trig(trig), .adc_data(adc_data), .adc_strobe(adc_strobe),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_empty(fifo_empty),
        .done(done)
    );

    always @(negedge clk) adc_data <= adc_data + 8'd1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_arm(input bit rt, input bit c);
        mode_rt = rt; cont = c; arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    // Counts strobe cycles seen at negedges over n cycles.
    task automatic count_strobes(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (adc_strobe) cnt++;
        end
    endtask

    int lat, extra, burst;
    logic [DW-1:0] seen_data;

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!done && !fifo_wr && !adc_strobe, "R10", {done, fifo_wr, adc_strobe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !fifo_wr && !adc_strobe, "R10", {done, fifo_wr, adc_strobe}, 0);

        // R1: trigger in idle is ignored
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        count_strobes(6, extra);
        check(extra == 0, "R1 idle trig", extra, 0);

        // Equivalent-time capture, single mode
        pulse_arm(1'b0, 1'b0);
        check(!done, "R1 armed", done, 0);
        for (int k = 0; k < NPTS; k++) begin
            repeat (GAP[k]) @(negedge clk);
            trig = 1'b1;
            lat = 0;
            seen_data = '0;
            while (lat < 100) begin
                @(negedge clk);
                lat++;
                if (lat == 1) trig = 1'b0;
                if (STRAY[k] && lat == 2 && k >= 3) trig = 1'b1;
                if (STRAY[k] && lat == 3) trig = 1'b0;
                if (adc_strobe) begin
                    seen_data = adc_data;
                    break;
                end
            end
            // R2 / R3: strobe k+1 edges after the edge that saw trig
            check(lat == k + 2, (k == 0) ? "R2 first point" : "R3 delay", lat, k + 2);
            // R5: write with ADC data
            check(fifo_wr && fifo_wdata == seen_data, "R5 write", fifo_wdata, seen_data);
            if (k != NPTS - 1) begin
                count_strobes(2, extra);
                // R4: no extra strobe from a stray trigger
                check(extra == 0, "R4 stray", extra, 0);
            end
        end
        @(negedge clk);
        // R7: done after last point
        check(done, "R7 done", done, 1);

        // R7 / R8: triggers ignored, done held in single mode
        fifo_empty = 1'b1;
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        count_strobes(20, extra);
        check(extra == 0, "R7 ignore", extra, 0);
        check(done, "R8 single hold", done, 1);
        fifo_empty = 1'b0;

        // R6: real-time burst
        pulse_arm(1'b1, 1'b0);
        burst = 0;
        while (adc_strobe && fifo_wr && burst < 1000) begin
            burst++;
            @(negedge clk);
        end
        check(burst == NPTS, "R6 burst", burst, NPTS);
        check(done, "R7 rt done", done, 1);

        // R9: continuous re-arm waits for drain
        pulse_arm(1'b1, 1'b1);
        repeat (NPTS) @(negedge clk);
        check(done, "R9 done", done, 1);
        count_strobes(10, extra);
        check(extra == 0 && done, "R9 wait drain", extra, 0);
        fifo_empty = 1'b1;
        @(negedge clk);
        check(!done && adc_strobe, "R9 rearm", {done, adc_strobe}, 1);
        fifo_empty = 1'b0;
        burst = 1;
        @(negedge clk);
        while (adc_strobe && burst < 1000) begin
            burst++;
            @(negedge clk);
        end
        check(burst == NPTS && done, "R9 second burst", burst, NPTS);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule